// File: doc/BRIEF.md
# Serial Bus Controller Register Front End

This block is the software-facing register file of a two-wire serial bus controller. A host writes configuration words over a plain 32-bit register bus and starts or aborts transactions through a control register. The block hands the stored configuration to the serial engine: clock divider, output delay, register address, write data, command code and device addresses. It also shows software the engine's completion and error reports as interrupt status. The serial timing engine lives outside this block. Its only contact with the front end is a one-cycle start pulse, an abort pulse, a soft-reset pulse and its own single-cycle result strobes.

A transfer in flight is visible as the start bit of the control register. A second start issued during that time is refused and flagged as a load-busy event. Status flags are cleared by writing ones to them. The interrupt output is a masked OR of status, gated by a global enable. Software can also take the two bus lines over directly and read their live levels.

Top module: `sbus_regfront`

## Requirements
- R1: After reset every register reads zero except the two live line bits of line control (bit 4 = `sda_in`, bit 5 = `scl_in`), and `irq_o`, `xfer_start_o`, `xfer_abort_o` and `soft_rst_o` are low.
- R2: Registers sit at these byte offsets and keep only these bits. Clock control at 0x04 keeps the divider in bits 7:0 and the data-line output delay in bits 10:8. Interrupt enable at 0x08 keeps bits 0, 1, 2, 11:8 and 16. Register address at 0x10 keeps 8 bits. Command at 0x2C keeps 8 bits. Device address at 0x30 keeps the hardware address in bits 15:0 and the runtime address in bits 23:16.
- R3: A write to control (0x00) with bit 7 set and bit 6 clear while idle sets control bit 7 at that clock edge and raises `xfer_start_o` for exactly one cycle.
- R4: An `eng_done` strobe during a transfer clears control bit 7 and sets status (0x0C) bit 0 at the same edge.
- R5: A start write during a transfer sets status bit 2 (load busy), produces no start pulse and leaves control bit 7 set.
- R6: An `eng_err` strobe during a transfer clears control bit 7 and sets status bit 1. It ORs `eng_lane_err` into status bits 11:8 and sets status bit 16 when `eng_nack` is high.
- R7: Writing one to a status bit clears it and writing zero leaves it unchanged. When an event sets a bit at the same edge that a write clears it, the bit stays set.
- R8: `irq_o` is high exactly when control bit 1 (global enable) is set and some status bit is set together with its enable bit.
- R9: A control write with bit 6 set ends any transfer by clearing bit 7, pulses `xfer_abort_o` for one cycle and leaves status untouched. It wins over bit 7 in the same write, so no start pulse and no load-busy flag result.
- R10: `eng_done` and `eng_err` strobes arriving while no transfer runs change neither status nor the data register.
- R11: On `eng_done` the data register (0x1C) captures `eng_rdata` masked by the command code: 0x8B keeps bits 7:0, 0x9C keeps 15:0, 0xA6 keeps 31:0. With any other command the data register keeps the value software wrote.
- R12: Line control (0x24) bits 3:0 drive `sda_oe_o`, `sda_o`, `scl_oe_o`, `scl_o` in that order, and bits 5:4 read the live `scl_in`, `sda_in`.
- R13: Writing control bit 0 raises `soft_rst_o` for one cycle with control bit 0 reading one. At the following edge every register returns to its reset value.
- R14: Device-mode control (0x28) stores all 32 bits. Bit 31 drives `dm_start_o` and clears itself on `eng_dm_done` while the other bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_done | input | 1 | Engine transfer-complete strobe |
| eng_err | input | 1 | Engine transfer-error strobe |
| eng_nack | input | 1 | Error was a missing acknowledge |
| eng_lane_err | input | 4 | Per-byte parity error flags |
| eng_rdata | input | 32 | Data read by the engine |
| eng_dm_done | input | 1 | Device-mode sequence finished |
| sda_in | input | 1 | Live data line level |
| scl_in | input | 1 | Live clock line level |
| xfer_start_o | output | 1 | One-cycle transfer start |
| xfer_abort_o | output | 1 | One-cycle transfer abort |
| soft_rst_o | output | 1 | One-cycle engine reset |
| dm_start_o | output | 1 | Device-mode sequence request |
| dm_cfg_o | output | 31 | Device-mode parameter bits |
| cfg_div | output | 8 | Clock divider |
| cfg_dly | output | 3 | Data-line output delay |
| cfg_regaddr | output | 8 | Target register address |
| cfg_wdata | output | 32 | Data register contents |
| cfg_cmd | output | 8 | Command code |
| cfg_rtaddr | output | 8 | Runtime device address |
| cfg_hwaddr | output | 16 | Hardware device address |
| sda_oe_o | output | 1 | Data line override enable |
| sda_o | output | 1 | Data line override level |
| scl_oe_o | output | 1 | Clock line override enable |
| scl_o | output | 1 | Clock line override level |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench hits a second start during a transfer. A design that queued it or restarted the engine would show a second start pulse and no load-busy flag. It lands a status-clearing write on the same edge as a completion, where a design that let the clear win would lose the event. It sends an abort combined with a start and then a late completion strobe after the abort. Either a spurious start or a status and data change would reveal a wrong priority or a missing busy gate. It also steps through the three read widths, then a write command whose completion must leave software's data alone, and it checks that a soft reset returns every register to zero.

// File: rtl/sbus_regfront_pkg.sv
`timescale 1ns/1ps
package sbus_regfront_pkg;
  localparam int DW     = 32;
  localparam int DIV_W  = 8;
  localparam int DLY_W  = 3;
  localparam int CCR_W  = DIV_W + DLY_W;
  localparam int RA_W   = 8;
  localparam int HW_W   = 16;
  localparam int RT_W   = 8;
  localparam int DAR_W  = HW_W + RT_W;
  localparam int CMD_W  = 8;
  localparam int LCR_W  = 4;
  localparam int LANES  = 4;

  // register byte offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_CCR  = 'h04;
  localparam int OFS_IEN  = 'h08;
  localparam int OFS_STS  = 'h0C;
  localparam int OFS_RA   = 'h10;
  localparam int OFS_DATA = 'h1C;
  localparam int OFS_LCR  = 'h24;
  localparam int OFS_DM   = 'h28;
  localparam int OFS_CMD  = 'h2C;
  localparam int OFS_DAR  = 'h30;

  // control bits
  localparam int CTL_GO   = 7;
  localparam int CTL_STOP = 6;
  localparam int CTL_GIE  = 1;
  localparam int CTL_SRST = 0;

  // status bits
  localparam int ST_DONE  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_LB    = 2;
  localparam int ST_LANE0 = 8;
  localparam int ST_NACK  = 16;
  localparam int STS_W    = ST_NACK + 1;

  // read command codes decoded by the engine
  localparam logic [CMD_W-1:0] CMD_RD_B = 8'h8B;
  localparam logic [CMD_W-1:0] CMD_RD_H = 8'h9C;
  localparam logic [CMD_W-1:0] CMD_RD_W = 8'hA6;

  function automatic logic [STS_W-1:0] sts_impl_mask();
    logic [STS_W-1:0] m;
    m = '0;
    m[ST_DONE] = 1'b1;
    m[ST_ERR]  = 1'b1;
    m[ST_LB]   = 1'b1;
    for (int i = 0; i < LANES; i++) m[ST_LANE0+i] = 1'b1;
    m[ST_NACK] = 1'b1;
    return m;
  endfunction

  localparam logic [STS_W-1:0] STS_IMPL = sts_impl_mask();

  function automatic logic is_read_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_RD_B) || (c == CMD_RD_H) || (c == CMD_RD_W);
  endfunction

  function automatic logic [DW-1:0] read_keep(input logic [CMD_W-1:0] c);
    case (c)
      CMD_RD_B: return {{(DW-8){1'b0}}, 8'hFF};
      CMD_RD_H: return {{(DW-16){1'b0}}, 16'hFFFF};
      default:  return '1;
    endcase
  endfunction

  function automatic logic [STS_W-1:0] w1c_next(input logic [STS_W-1:0] cur,
                                                input logic [STS_W-1:0] clr,
                                                input logic [STS_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sbus_ctl_unit.sv
`timescale 1ns/1ps
module sbus_ctl_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       eng_done,
  input  logic       eng_err,
  output logic       busy_o,
  output logic       gie_o,
  output logic       srst_o,
  output logic       start_o,
  output logic       abort_o,
  output logic       acc_done_o,
  output logic       acc_err_o,
  output logic       lb_ev_o
);
  import sbus_regfront_pkg::*;

  logic busy_q, gie_q, srst_q, start_q, abort_q;
  logic stop_req, go_req, go_ok;

  assign stop_req   = ctrl_wr & ctrl_wdata[CTL_STOP];
  assign go_req     = ctrl_wr & ctrl_wdata[CTL_GO] & ~stop_req;
  assign go_ok      = go_req & ~busy_q;
  assign lb_ev_o    = go_req & busy_q;
  assign acc_done_o = busy_q & eng_done;
  assign acc_err_o  = busy_q & eng_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      gie_q   <= 1'b0;
      srst_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else if (srst_q) begin
      busy_q  <= 1'b0;
      gie_q   <= 1'b0;
      srst_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      start_q <= go_ok;
      abort_q <= stop_req;
      if (ctrl_wr) begin
        gie_q  <= ctrl_wdata[CTL_GIE];
        srst_q <= ctrl_wdata[CTL_SRST];
      end
      if (stop_req)                       busy_q <= 1'b0;
      else if (go_ok)                     busy_q <= 1'b1;
      else if (acc_done_o || acc_err_o)   busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign gie_o   = gie_q;
  assign srst_o  = srst_q;
  assign start_o = start_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/sbus_sts_unit.sv
`timescale 1ns/1ps
module sbus_sts_unit #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] ien,
  input  logic         gie,
  output logic [W-1:0] sts_o,
  output logic         irq_o
);
  import sbus_regfront_pkg::*;

  logic [W-1:0] sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sts_q <= '0;
    else if (srst) sts_q <= '0;
    else           sts_q <= w1c_next(sts_q, clr_vec, set_vec);
  end

  assign sts_o = sts_q;
  assign irq_o = gie & (|(sts_q & ien));
endmodule

// File: rtl/sbus_cfg_unit.sv
`timescale 1ns/1ps
module sbus_cfg_unit
  import sbus_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_ccr,
  input  logic              wr_ien,
  input  logic              wr_ra,
  input  logic              wr_data,
  input  logic              wr_lcr,
  input  logic              wr_dm,
  input  logic              wr_cmd,
  input  logic              wr_dar,
  input  logic [DW-1:0]     wdata,
  input  logic              cap_en,
  input  logic [DW-1:0]     cap_val,
  input  logic              dm_done,
  output logic [CCR_W-1:0]  ccr_o,
  output logic [STS_W-1:0]  ien_o,
  output logic [RA_W-1:0]   ra_o,
  output logic [DW-1:0]     data_o,
  output logic [LCR_W-1:0]  lcr_o,
  output logic [DW-1:0]     dm_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DAR_W-1:0]  dar_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_o <= '0; ien_o <= '0; ra_o <= '0; data_o <= '0;
      lcr_o <= '0; dm_o <= '0; cmd_o <= '0; dar_o <= '0;
    end else if (srst) begin
      ccr_o <= '0; ien_o <= '0; ra_o <= '0; data_o <= '0;
      lcr_o <= '0; dm_o <= '0; cmd_o <= '0; dar_o <= '0;
    end else begin
      if (wr_ccr) ccr_o <= wdata[CCR_W-1:0];
      if (wr_ien) ien_o <= wdata[STS_W-1:0] & STS_IMPL;
      if (wr_ra)  ra_o  <= wdata[RA_W-1:0];
      if (wr_lcr) lcr_o <= wdata[LCR_W-1:0];
      if (wr_cmd) cmd_o <= wdata[CMD_W-1:0];
      if (wr_dar) dar_o <= wdata[DAR_W-1:0];
      if (cap_en)       data_o <= cap_val;
      else if (wr_data) data_o <= wdata;
      if (wr_dm)        dm_o <= wdata;
      else if (dm_done) dm_o[DW-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/sbus_regfront.sv
`timescale 1ns/1ps
module sbus_regfront
  import sbus_regfront_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_nack,
  input  logic [3:0]        eng_lane_err,
  input  logic [31:0]       eng_rdata,
  input  logic              eng_dm_done,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              xfer_start_o,
  output logic              xfer_abort_o,
  output logic              soft_rst_o,
  output logic              dm_start_o,
  output logic [30:0]       dm_cfg_o,
  output logic [7:0]        cfg_div,
  output logic [2:0]        cfg_dly,
  output logic [7:0]        cfg_regaddr,
  output logic [31:0]       cfg_wdata,
  output logic [7:0]        cfg_cmd,
  output logic [7:0]        cfg_rtaddr,
  output logic [15:0]       cfg_hwaddr,
  output logic              sda_oe_o,
  output logic              sda_o,
  output logic              scl_oe_o,
  output logic              scl_o,
  output logic              irq_o
);
  // named internal events, also observed by the checker
  logic busy_q, gie_q, srst_q;
  logic acc_done, acc_err, lb_ev, ev_any;
  logic [STS_W-1:0] sts_q, ien_q, sts_set, sts_clr;
  logic [CCR_W-1:0] ccr_q;
  logic [RA_W-1:0]  ra_q;
  logic [DW-1:0]    data_q, dm_q;
  logic [LCR_W-1:0] lcr_q;
  logic [CMD_W-1:0] cmd_q;
  logic [DAR_W-1:0] dar_q;
  logic hit_ctrl, hit_ccr, hit_ien, hit_sts, hit_ra, hit_data;
  logic hit_lcr, hit_dm, hit_cmd, hit_dar;
  logic cap_en;
  logic [DW-1:0] cap_val;

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_ccr  = (bus_addr == ADDR_W'(OFS_CCR));
  assign hit_ien  = (bus_addr == ADDR_W'(OFS_IEN));
  assign hit_sts  = (bus_addr == ADDR_W'(OFS_STS));
  assign hit_ra   = (bus_addr == ADDR_W'(OFS_RA));
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_lcr  = (bus_addr == ADDR_W'(OFS_LCR));
  assign hit_dm   = (bus_addr == ADDR_W'(OFS_DM));
  assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
  assign hit_dar  = (bus_addr == ADDR_W'(OFS_DAR));

  sbus_ctl_unit u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (bus_wr & hit_ctrl),
    .ctrl_wdata (bus_wdata[7:0]),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .busy_o     (busy_q),
    .gie_o      (gie_q),
    .srst_o     (srst_q),
    .start_o    (xfer_start_o),
    .abort_o    (xfer_abort_o),
    .acc_done_o (acc_done),
    .acc_err_o  (acc_err),
    .lb_ev_o    (lb_ev)
  );

  assign ev_any = acc_done | acc_err;

  always_comb begin
    sts_set          = '0;
    sts_set[ST_DONE] = acc_done;
    sts_set[ST_ERR]  = acc_err;
    sts_set[ST_LB]   = lb_ev;
    sts_set[ST_NACK] = acc_err & eng_nack;
    for (int i = 0; i < LANES; i++)
      sts_set[ST_LANE0+i] = acc_err & eng_lane_err[i];
  end

  assign sts_clr = (bus_wr & hit_sts) ? bus_wdata[STS_W-1:0] : '0;

  sbus_sts_unit #(.W(STS_W)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_q),
    .set_vec (sts_set),
    .clr_vec (sts_clr),
    .ien     (ien_q),
    .gie     (gie_q),
    .sts_o   (sts_q),
    .irq_o   (irq_o)
  );

  assign cap_en  = acc_done & is_read_cmd(cmd_q);
  assign cap_val = eng_rdata & read_keep(cmd_q);

  sbus_cfg_unit u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_q),
    .wr_ccr  (bus_wr & hit_ccr),
    .wr_ien  (bus_wr & hit_ien),
    .wr_ra   (bus_wr & hit_ra),
    .wr_data (bus_wr & hit_data),
    .wr_lcr  (bus_wr & hit_lcr),
    .wr_dm   (bus_wr & hit_dm),
    .wr_cmd  (bus_wr & hit_cmd),
    .wr_dar  (bus_wr & hit_dar),
    .wdata   (bus_wdata),
    .cap_en  (cap_en),
    .cap_val (cap_val),
    .dm_done (eng_dm_done),
    .ccr_o   (ccr_q),
    .ien_o   (ien_q),
    .ra_o    (ra_q),
    .data_o  (data_q),
    .lcr_o   (lcr_q),
    .dm_o    (dm_q),
    .cmd_o   (cmd_q),
    .dar_o   (dar_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (1'b1)
      hit_ctrl: begin
        bus_rdata[CTL_GO]   = busy_q;
        bus_rdata[CTL_GIE]  = gie_q;
        bus_rdata[CTL_SRST] = srst_q;
      end
      hit_ccr:  bus_rdata[CCR_W-1:0] = ccr_q;
      hit_ien:  bus_rdata[STS_W-1:0] = ien_q;
      hit_sts:  bus_rdata[STS_W-1:0] = sts_q;
      hit_ra:   bus_rdata[RA_W-1:0]  = ra_q;
      hit_data: bus_rdata            = data_q;
      hit_lcr:  bus_rdata[LCR_W+1:0] = {scl_in, sda_in, lcr_q};
      hit_dm:   bus_rdata            = dm_q;
      hit_cmd:  bus_rdata[CMD_W-1:0] = cmd_q;
      hit_dar:  bus_rdata[DAR_W-1:0] = dar_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign soft_rst_o  = srst_q;
  assign dm_start_o  = dm_q[DW-1];
  assign dm_cfg_o    = dm_q[DW-2:0];
  assign cfg_div     = ccr_q[DIV_W-1:0];
  assign cfg_dly     = ccr_q[CCR_W-1:DIV_W];
  assign cfg_regaddr = ra_q;
  assign cfg_wdata   = data_q;
  assign cfg_cmd     = cmd_q;
  assign cfg_hwaddr  = dar_q[HW_W-1:0];
  assign cfg_rtaddr  = dar_q[DAR_W-1:HW_W];
  assign sda_oe_o    = lcr_q[0];
  assign sda_o       = lcr_q[1];
  assign scl_oe_o    = lcr_q[2];
  assign scl_o       = lcr_q[3];
endmodule

// File: rtl/sbus_regfront_chk.sv
`timescale 1ns/1ps
module sbus_regfront_chk
  import sbus_regfront_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start,
  input logic             abort,
  input logic             srst,
  input logic             ev_any,
  input logic             gie,
  input logic             irq,
  input logic [STS_W-1:0] sts
);
  // R3
  start_on_busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R4
  event_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> !busy);

  // R5
  load_busy_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[ST_LB]) |-> $past(busy));

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !busy);

  // R13
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (sts == '0) && !busy && !gie);
endmodule

bind sbus_regfront sbus_regfront_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy_q),
  .start  (xfer_start_o),
  .abort  (xfer_abort_o),
  .srst   (srst_q),
  .ev_any (ev_any),
  .gie    (gie_q),
  .irq    (irq_o),
  .sts    (sts_q)
);

// File: tb/test_sbus_regfront.sv
`timescale 1ns/1ps
module test_sbus_regfront;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic eng_done = 0, eng_err = 0, eng_nack = 0, eng_dm_done = 0;
  logic [3:0] eng_lane_err = '0;
  logic [31:0] eng_rdata = '0;
  logic sda_in = 0, scl_in = 0;
  logic xfer_start_o, xfer_abort_o, soft_rst_o, dm_start_o;
  logic [30:0] dm_cfg_o;
  logic [7:0] cfg_div, cfg_regaddr, cfg_cmd, cfg_rtaddr;
  logic [2:0] cfg_dly;
  logic [31:0] cfg_wdata;
  logic [15:0] cfg_hwaddr;
  logic sda_oe_o, sda_o, scl_oe_o, scl_o, irq_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sbus_regfront i_sbus_regfront (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
    .eng_err(eng_err), .eng_nack(eng_nack), .eng_lane_err(eng_lane_err),
    .eng_rdata(eng_rdata), .eng_dm_done(eng_dm_done), .sda_in(sda_in),
    .scl_in(scl_in), .xfer_start_o(xfer_start_o), .xfer_abort_o(xfer_abort_o),
    .soft_rst_o(soft_rst_o), .dm_start_o(dm_start_o), .dm_cfg_o(dm_cfg_o),
    .cfg_div(cfg_div), .cfg_dly(cfg_dly), .cfg_regaddr(cfg_regaddr),
    .cfg_wdata(cfg_wdata), .cfg_cmd(cfg_cmd), .cfg_rtaddr(cfg_rtaddr),
    .cfg_hwaddr(cfg_hwaddr), .sda_oe_o(sda_oe_o), .sda_o(sda_o),
    .scl_oe_o(scl_oe_o), .scl_o(scl_o), .irq_o(irq_o)
  );

  // behavioural reference model, advanced on every rising edge
  bit m_busy, m_gie, m_srst, m_go, m_stop;
  logic [31:0] m_sts, m_ien, m_ccr, m_data, m_lcr, m_dm, m_cmd;
  bit nbusy, took_done, took_err;

  always @(posedge clk) begin
    if (!rst_n || m_srst) begin
      m_busy = 0; m_gie = 0; m_srst = 0; m_go = 0; m_stop = 0;
      m_sts = 0; m_ien = 0; m_ccr = 0; m_data = 0; m_lcr = 0; m_dm = 0; m_cmd = 0;
    end else begin
      took_done = m_busy && eng_done;
      took_err  = m_busy && eng_err;
      nbusy = m_busy;
      if (took_done || took_err) nbusy = 0;
      m_go = 0; m_stop = 0;
      if (bus_wr && bus_addr == 8'h0C) m_sts = m_sts & ~bus_wdata;
      if (took_done) m_sts[0] = 1;
      if (took_err) begin
        m_sts[1] = 1;
        if (eng_nack) m_sts[16] = 1;
        m_sts[11:8] = m_sts[11:8] | eng_lane_err;
      end
      if (bus_wr && bus_addr == 8'h00) begin
        m_gie = bus_wdata[1];
        m_srst = bus_wdata[0];
        if (bus_wdata[6]) begin
          m_stop = 1; nbusy = 0;
        end else if (bus_wdata[7]) begin
          if (m_busy) m_sts[2] = 1;
          else begin m_go = 1; nbusy = 1; end
        end
      end
      if (took_done && (m_cmd == 32'h8B)) m_data = eng_rdata & 32'hFF;
      else if (took_done && (m_cmd == 32'h9C)) m_data = eng_rdata & 32'hFFFF;
      else if (took_done && (m_cmd == 32'hA6)) m_data = eng_rdata;
      else if (bus_wr && bus_addr == 8'h1C) m_data = bus_wdata;
      if (bus_wr && bus_addr == 8'h08) m_ien = bus_wdata & 32'h0001_0F07;
      if (bus_wr && bus_addr == 8'h04) m_ccr = bus_wdata & 32'h7FF;
      if (bus_wr && bus_addr == 8'h24) m_lcr = bus_wdata & 32'hF;
      if (bus_wr && bus_addr == 8'h2C) m_cmd = bus_wdata & 32'hFF;
      if (bus_wr && bus_addr == 8'h28) m_dm = bus_wdata;
      else if (eng_dm_done) m_dm[31] = 0;
      m_busy = nbusy;
    end
  end

  // per-clock comparison of the outputs that depend on state only
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (irq_o !== (m_gie && ((m_sts & m_ien) != 0))) begin
        fails++; $display("FAIL R8 irq_o got %0b exp %0b", irq_o, m_gie && ((m_sts & m_ien) != 0));
      end
      if (xfer_start_o !== m_go) begin
        fails++; $display("FAIL R3 xfer_start_o got %0b exp %0b", xfer_start_o, m_go);
      end
      if (xfer_abort_o !== m_stop) begin
        fails++; $display("FAIL R9 xfer_abort_o got %0b exp %0b", xfer_abort_o, m_stop);
      end
      if (soft_rst_o !== m_srst) begin
        fails++; $display("FAIL R13 soft_rst_o got %0b exp %0b", soft_rst_o, m_srst);
      end
      if (dm_start_o !== m_dm[31]) begin
        fails++; $display("FAIL R14 dm_start_o got %0b exp %0b", dm_start_o, m_dm[31]);
      end
      if ({scl_o, scl_oe_o, sda_o, sda_oe_o} !== m_lcr[3:0]) begin
        fails++; $display("FAIL R12 line outs got %h exp %h", {scl_o, scl_oe_o, sda_o, sda_oe_o}, m_lcr[3:0]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic rchk(input string req, input int a, input logic [31:0] exp);
    bus_addr = a[7:0];
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[7:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic eng(input bit d, input bit e, input bit n, input logic [3:0] l,
                     input logic [31:0] rd);
    @(negedge clk);
    eng_done = d; eng_err = e; eng_nack = n; eng_lane_err = l; eng_rdata = rd;
    @(negedge clk);
    eng_done = 0; eng_err = 0; eng_nack = 0; eng_lane_err = 0;
  endtask

  initial begin
    int offs[10] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h1C, 'h24, 'h28, 'h2C, 'h30};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 10; i++) rchk("R1", offs[i], 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 pulses", {29'b0, xfer_start_o, xfer_abort_o, soft_rst_o}, 0);

    // R2 field widths
    wreg('h04, 32'hFFFF_FFFF); rchk("R2 ccr", 'h04, 32'h7FF);
    chk("R2 div", {24'b0, cfg_div}, 32'hFF); chk("R2 dly", {29'b0, cfg_dly}, 7);
    wreg('h10, 32'hFFFF_FFFF); rchk("R2 regaddr", 'h10, 32'hFF);
    wreg('h30, 32'hFFFF_FFFF); rchk("R2 dar", 'h30, 32'hFF_FFFF);
    wreg('h30, 32'h002D_03A3);
    chk("R2 rtaddr", {24'b0, cfg_rtaddr}, 32'h2D); chk("R2 hwaddr", {16'b0, cfg_hwaddr}, 32'h3A3);
    wreg('h08, 32'hFFFF_FFFF); rchk("R2 ien", 'h08, 32'h0001_0F07);
    wreg('h2C, 32'hFFFF_FFFF); rchk("R2 cmd", 'h2C, 32'hFF);
    wreg('h08, 0);
    wreg('h2C, 32'h8B);

    // R3 start
    wreg('h00, 32'h82);
    chk("R3 pulse", {31'b0, xfer_start_o}, 1);
    rchk("R3 ctrl", 'h00, 32'h82);
    @(negedge clk); chk("R3 pulse end", {31'b0, xfer_start_o}, 0);

    // R5 second start during transfer
    wreg('h00, 32'h82);
    chk("R5 no pulse", {31'b0, xfer_start_o}, 0);
    rchk("R5 sts", 'h0C, 32'h4);
    rchk("R5 ctrl", 'h00, 32'h82);

    // R4 / R11 completion with byte read
    eng(1, 0, 0, 0, 32'hDEAD_BEEF);
    rchk("R4 ctrl", 'h00, 32'h02);
    rchk("R4 sts", 'h0C, 32'h5);
    rchk("R11 byte", 'h1C, 32'hEF);

    // R8 interrupt gating
    chk("R8 masked", {31'b0, irq_o}, 0);
    wreg('h08, 32'h1);  chk("R8 done en", {31'b0, irq_o}, 1);
    wreg('h00, 32'h00); chk("R8 gie off", {31'b0, irq_o}, 0);
    wreg('h00, 32'h02); chk("R8 gie on", {31'b0, irq_o}, 1);
    wreg('h08, 32'h10000); chk("R8 other bit", {31'b0, irq_o}, 0);

    // R7 write-one-to-clear and set priority
    wreg('h0C, 32'h4); rchk("R7 clear lb", 'h0C, 32'h1);
    wreg('h00, 32'h82);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h1; eng_done = 1; eng_rdata = 32'h0;
    @(negedge clk);
    bus_wr = 0; eng_done = 0;
    rchk("R7 set wins", 'h0C, 32'h1);
    rchk("R11 byte zero", 'h1C, 32'h0);
    wreg('h0C, 32'h1); rchk("R7 cleared", 'h0C, 32'h0);

    // R6 error report
    wreg('h2C, 32'h9C);
    wreg('h00, 32'h82);
    eng(0, 1, 1, 4'b0101, 32'hFFFF_FFFF);
    rchk("R6 sts", 'h0C, 32'h0001_0502);
    rchk("R6 ctrl", 'h00, 32'h02);
    rchk("R6 data kept", 'h1C, 32'h0);
    chk("R8 nack irq", {31'b0, irq_o}, 1);
    wreg('h0C, 32'hFFFF_FFFF); rchk("R7 all clear", 'h0C, 32'h0);

    // R11 widths
    wreg('h00, 32'h82); eng(1, 0, 0, 0, 32'h1234_5678);
    rchk("R11 half", 'h1C, 32'h5678);
    wreg('h2C, 32'hA6); wreg('h00, 32'h82); eng(1, 0, 0, 0, 32'h89AB_CDEF);
    rchk("R11 word", 'h1C, 32'h89AB_CDEF);
    wreg('h1C, 32'hCAFE_F00D);
    wreg('h2C, 32'h4E); wreg('h00, 32'h82); eng(1, 0, 0, 0, 32'h1111_1111);
    rchk("R11 write cmd", 'h1C, 32'hCAFE_F00D);
    chk("R11 cfg_wdata", cfg_wdata, 32'hCAFE_F00D);
    wreg('h0C, 32'hFFFF_FFFF);

    // R9 abort beats start
    wreg('h00, 32'h82);
    wreg('h00, 32'hC2);
    chk("R9 abort pulse", {31'b0, xfer_abort_o}, 1);
    chk("R9 no start", {31'b0, xfer_start_o}, 0);
    rchk("R9 ctrl", 'h00, 32'h02);
    rchk("R9 sts", 'h0C, 32'h0);

    // R10 late strobes ignored
    eng(1, 0, 0, 0, 32'h55);
    rchk("R10 sts done", 'h0C, 32'h0);
    rchk("R10 data", 'h1C, 32'hCAFE_F00D);
    eng(0, 1, 1, 4'hF, 0);
    rchk("R10 sts err", 'h0C, 32'h0);

    // R12 line control
    sda_in = 1; scl_in = 0;
    wreg('h24, 32'hFF);
    chk("R12 outs", {28'b0, scl_o, scl_oe_o, sda_o, sda_oe_o}, 32'hF);
    rchk("R12 read", 'h24, 32'h1F);
    sda_in = 0; scl_in = 1;
    wreg('h24, 32'h5);
    chk("R12 outs2", {28'b0, scl_o, scl_oe_o, sda_o, sda_oe_o}, 32'h5);
    rchk("R12 read2", 'h24, 32'h25);

    // R14 device-mode start
    wreg('h28, 32'h807C_3E00);
    chk("R14 start", {31'b0, dm_start_o}, 1);
    rchk("R14 read", 'h28, 32'h807C_3E00);
    @(negedge clk); chk("R14 held", {31'b0, dm_start_o}, 1);
    @(negedge clk); eng_dm_done = 1; @(negedge clk); eng_dm_done = 0;
    rchk("R14 cleared", 'h28, 32'h007C_3E00);
    chk("R14 cfg", {1'b0, dm_cfg_o}, 32'h007C_3E00);

    // R13 soft reset
    wreg('h00, 32'h03);
    chk("R13 pulse", {31'b0, soft_rst_o}, 1);
    rchk("R13 ctrl", 'h00, 32'h03);
    @(negedge clk);
    chk("R13 pulse end", {31'b0, soft_rst_o}, 0);
    rchk("R13 ctrl0", 'h00, 0);
    rchk("R13 ccr", 'h04, 0);
    rchk("R13 ien", 'h08, 0);
    rchk("R13 data", 'h1C, 0);
    rchk("R13 lcr", 'h24, 32'h20);
    rchk("R13 dm", 'h28, 0);
    rchk("R13 dar", 'h30, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule